// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a three-wire serial memory. A host selects it with a chip-select line, then clocks a frame in over a serial data line: a start bit, a two-bit opcode, an address and, for the commands that store data, a data word. The block holds a small byte array and can read one word, write one word, erase one word, erase the whole array or fill the whole array. It can also set or clear a write-enable latch. All serial inputs are brought into the system clock domain through two-flop synchronizers. A serial clock rising edge is detected from the synchronized samples.

Every write or erase starts a self-timed program cycle that lasts a fixed number of system clocks. The cycle runs to the end whether or not select stays high. While a cycle is running, raising select again turns the data-out pin into a ready/busy flag. An organization input sets the word width to 8 or 16 bits, and the total capacity stays the same. The data-out pin is modelled as a value plus an output-enable, so a high-impedance pin is an enable of 0.

Top module: `mw_eeprom`

## Requirements
- R1: While select is low the serial logic stays in its idle state and the data-out enable is 0. A frame cut short by dropping select changes no memory. After reset the whole array reads as all ones.
- R2: While select is high and no program cycle runs, data-in samples of 0 taken before the first 1 are ignored. The first sampled 1 is the start bit.
- R3: Read is opcode 10, followed by the address, MSB first. After the rising edge that samples the last address bit, data out is driven with a 0 dummy bit. Each following rising edge then drives one data bit, MSB first.
- R4: The serial clock may stay high or low for any length of time inside a frame without changing the result.
- R5: Write is opcode 01 followed by the address and the data, MSB first. Erase is opcode 11 followed by the address, and it sets the word to all ones.
- R6: Opcode 00 with top address bits 11 sets the write-enable latch. Opcode 00 with top address bits 00 clears it. The latch is clear after reset. Write, erase, erase-all and write-all have no effect while the latch is clear.
- R7: Opcode 00 with top address bits 10 sets every byte to FF. Opcode 00 with top address bits 01, followed by a data word, writes that word to every word location.
- R8: A program cycle lasts PROG_CYCLES system clocks and completes even when select is low. No new frame is accepted while it runs.
- R9: If select rises while a program cycle runs, data out is enabled and shows 0 until the cycle ends, then shows 1. If select stays low for the whole cycle, the enable stays 0.
- R10: A start bit clears the ready/busy indication, so after select is dropped and raised again the enable is 0.
- R11: When org16 is 1, words are 16 bits wide and the address is 8 bits. The high byte of word a is byte 2a and the low byte is byte 2a+1. When org16 is 0, words are bytes and the address is 9 bits.
- R12: Once a frame has completed, further clocks and data are ignored until select is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| org16 | input | 1 | Word width select: 1 gives 16-bit words, 0 gives 8-bit words |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Data-out enable; 0 means high impedance |

## Verification
The main path is exercised by vectors that write in one word width and read back in the other. This separates the byte order within a 16-bit word from the address width used in each mode. Erase and write patterns are applied with the write-enable latch both set and cleared, which separates a rejected command from an accepted one. Directed frames add leading zeros, a long clock stall, frames aborted by a deselect, and trailing bits after a complete frame. Further directed tests raise select at different points in a program cycle, so that busy, ready and high impedance can each be observed and told apart.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int MEM_BYTES   = 512,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  input  logic org16,
  output logic sdo,
  output logic sdo_oe
);
  localparam int BA = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_HUNT, S_OP, S_ADR, S_DAT, S_RD, S_DONE} st_t;

  logic [1:0] sel_q, sdi_q;
  logic [2:0] sck_q;
  logic       sel_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0; sdi_q <= '0; sck_q <= '0; sel_d <= 1'b0;
    end else begin
      sel_q <= {sel_q[0], sel};
      sdi_q <= {sdi_q[0], sdi};
      sck_q <= {sck_q[1:0], sclk};
      sel_d <= sel_q[1];
    end

  wire sel_s = sel_q[1];
  wire sdi_s = sdi_q[1];
  wire go    = sel_s && sck_q[1] && !sck_q[2];

  st_t           st;
  logic [4:0]    cnt;
  logic [1:0]    op;
  logic [BA-1:0] adr;
  logic [15:0]   dat, rsh;
  logic          wen, reading, sdo_r, status_en;
  logic [PW-1:0] prog_cnt;
  logic [7:0]    mem [MEM_BYTES];

  wire [4:0] aw   = org16 ? 5'(BA - 1) : 5'(BA);
  wire [4:0] dw   = org16 ? 5'd16 : 5'd8;
  wire       busy = prog_cnt != '0;

  wire [BA-1:0] adr_n    = {adr[BA-2:0], sdi_s};
  wire [15:0]   dat_n    = {dat[14:0], sdi_s};
  wire          last_adr = st == S_ADR && cnt == aw - 5'd1;
  wire          last_dat = st == S_DAT && cnt == dw - 5'd1;
  wire [BA-1:0] fa       = (st == S_ADR) ? adr_n : adr;
  wire [1:0]    ext      = org16 ? fa[BA-2 -: 2] : fa[BA-1 -: 2];
  wire [BA-1:0] hi_b     = {fa[BA-2:0], 1'b0};
  wire [BA-1:0] lo_b     = {fa[BA-2:0], 1'b1};

  wire do_wr1   = go && last_dat && op == 2'b01;
  wire do_erase = go && last_adr && op == 2'b11;
  wire do_eral  = go && last_adr && op == 2'b00 && ext == 2'b10;
  wire do_wral  = go && last_dat && op == 2'b00;
  wire do_ewen  = go && last_adr && op == 2'b00 && ext == 2'b11;
  wire do_ewds  = go && last_adr && op == 2'b00 && ext == 2'b00;

  wire        pg     = wen && !busy && (do_wr1 || do_erase || do_eral || do_wral);
  wire        pg_all = do_eral || do_wral;
  wire [15:0] pg_val = (do_erase || do_eral) ? 16'hFFFF : dat_n;
  wire [15:0] rd_w   = org16 ? {mem[hi_b], mem[lo_b]} : {mem[fa], 8'h00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (pg) begin
      if (pg_all) begin
        for (int i = 0; i < MEM_BYTES; i++)
          mem[i] <= (org16 && (i % 2 == 0)) ? pg_val[15:8] : pg_val[7:0];
      end else if (org16) begin
        mem[hi_b] <= pg_val[15:8];
        mem[lo_b] <= pg_val[7:0];
      end else begin
        mem[fa] <= pg_val[7:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_HUNT; cnt <= '0; op <= '0; adr <= '0; dat <= '0; rsh <= '0;
      reading <= 1'b0; sdo_r <= 1'b0;
    end else if (!sel_s) begin
      st <= S_HUNT; cnt <= '0; reading <= 1'b0;
    end else if (go) begin
      case (st)
        S_HUNT: if (!busy && sdi_s) begin st <= S_OP; cnt <= '0; end
        S_OP: begin
          op  <= {op[0], sdi_s};
          cnt <= cnt + 5'd1;
          if (cnt == 5'd1) begin st <= S_ADR; cnt <= '0; end
        end
        S_ADR: begin
          adr <= adr_n;
          cnt <= cnt + 5'd1;
          if (last_adr) begin
            cnt <= '0;
            if (op == 2'b10) begin
              st <= S_RD; reading <= 1'b1; sdo_r <= 1'b0;
              rsh <= rd_w;
            end else if (op == 2'b01 || (op == 2'b00 && ext == 2'b01))
              st <= S_DAT;
            else
              st <= S_DONE;
          end
        end
        S_DAT: begin
          dat <= dat_n;
          cnt <= cnt + 5'd1;
          if (last_dat) st <= S_DONE;
        end
        S_RD: begin
          if (cnt != dw) begin
            sdo_r <= rsh[15];
            rsh   <= {rsh[14:0], 1'b0};
            cnt   <= cnt + 5'd1;
          end else begin
            st <= S_DONE; reading <= 1'b0;
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wen <= 1'b0; prog_cnt <= '0; status_en <= 1'b0;
    end else begin
      if (do_ewen) wen <= 1'b1;
      else if (do_ewds) wen <= 1'b0;
      if (pg) prog_cnt <= PW'(PROG_CYCLES);
      else if (busy) prog_cnt <= prog_cnt - 1'b1;
      if (sel_s && !sel_d && busy) status_en <= 1'b1;
      else if (go && st == S_HUNT && !busy && sdi_s) status_en <= 1'b0;
    end

  assign sdo_oe = sel_s && (reading || status_en);
  assign sdo    = reading ? sdo_r : !busy;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> (st == S_HUNT && !reading)); // R1
  AST_READ_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reading) |-> !sdo_r); // R3
  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen && !busy) |=> !busy); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_cnt != PW'(1)) |=> busy); // R8
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_HUNT) |=> st == S_HUNT); // R8
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && sel_s) |=> (st == S_DONE || st == S_HUNT)); // R12
  AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_en && sel_s && !reading && busy) |-> (sdo_oe && !sdo)); // R9
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int PROG = 200;
  localparam int HP   = 6;
  localparam logic [2:0] RD = 0, WR = 1, ER = 2, EWEN = 3, EWDS = 4, ERAL = 5, WRAL = 6;
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {EWEN, 1'b1, 9'd0,   16'h0000, 16'h0000},
    {WR,   1'b1, 9'd5,   16'hA5C3, 16'h0000},
    {RD,   1'b1, 9'd5,   16'h0000, 16'hA5C3},
    {RD,   1'b0, 9'd10,  16'h0000, 16'h00A5},
    {RD,   1'b0, 9'd11,  16'h0000, 16'h00C3},
    {WR,   1'b0, 9'd20,  16'h003C, 16'h0000},
    {RD,   1'b1, 9'd10,  16'h0000, 16'h3CFF},
    {ER,   1'b1, 9'd5,   16'h0000, 16'h0000},
    {RD,   1'b1, 9'd5,   16'h0000, 16'hFFFF},
    {EWDS, 1'b1, 9'd0,   16'h0000, 16'h0000},
    {WR,   1'b1, 9'd7,   16'h1234, 16'h0000},
    {RD,   1'b1, 9'd7,   16'h0000, 16'hFFFF},
    {EWEN, 1'b0, 9'd0,   16'h0000, 16'h0000},
    {WRAL, 1'b1, 9'd0,   16'h5A69, 16'h0000},
    {RD,   1'b1, 9'd255, 16'h0000, 16'h5A69},
    {RD,   1'b0, 9'd511, 16'h0000, 16'h0069},
    {ERAL, 1'b0, 9'd0,   16'h0000, 16'h0000},
    {RD,   1'b0, 9'd300, 16'h0000, 16'h00FF}
  };

  logic clk = 0, rst_n = 0, sel = 0, sclk = 0, sdi = 0, org16 = 1;
  logic sdo, sdo_oe;
  int nchk = 0, nfail = 0;
  logic [15:0] w;

  always #2.5 clk = ~clk;

  mw_eeprom #(.MEM_BYTES(512), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .org16(org16), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic bit_out(input logic b, input int hi = HP);
    sdi = b; tick(HP); sclk = 1; tick(hi); sclk = 0;
  endtask
  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask
  task automatic sel_on;  sel = 1; tick(4); endtask
  task automatic sel_off; sel = 0; sdi = 0; tick(6); endtask

  task automatic frame(input logic [2:0] k, input logic o, input logic [8:0] a,
                       input logic [15:0] d, input bit drop = 1);
    int aw, dw;
    org16 = o; aw = o ? 8 : 9; dw = o ? 16 : 8;
    sel_on; bit_out(1);
    case (k)
      WR:   begin send(2'b01, 2); send(a, aw); send(d, dw); end
      ER:   begin send(2'b11, 2); send(a, aw); end
      EWEN: begin send(2'b00, 2); send(32'd3 << (aw - 2), aw); end
      EWDS: begin send(2'b00, 2); send(0, aw); end
      ERAL: begin send(2'b00, 2); send(32'd2 << (aw - 2), aw); end
      default: begin send(2'b00, 2); send(32'd1 << (aw - 2), aw); send(d, dw); end
    endcase
    if (drop) sel_off;
  endtask

  task automatic rd(input logic o, input logic [8:0] a, output logic [15:0] r,
                    input int lz = 0, input int stall = 0);
    int aw, dw;
    org16 = o; aw = o ? 8 : 9; dw = o ? 16 : 8;
    sel_on;
    for (int i = 0; i < lz; i++) bit_out(0);
    bit_out(1); send(2'b10, 2);
    for (int i = aw - 1; i >= 0; i--) bit_out(a[i], (i == 4) ? HP + stall : HP);
    chk("R3 dummy bit", {14'd0, sdo_oe, sdo}, 16'h0002);
    r = 0;
    for (int i = 0; i < dw; i++) begin bit_out(0); r = {r[14:0], sdo}; end
    sel_off;
  endtask

  initial begin
    tick(5000000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(3);
    chk("R1 reset oe", {15'd0, sdo_oe}, 16'h0000);
    rd(1, 9'd100, w);
    chk("R1 reset contents", w, 16'hFFFF);

    // R5 R6 R7 R11 vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][44:42] == RD) begin
        rd(VEC[v][41], VEC[v][40:32], w);
        chk($sformatf("R5/R6/R7/R11 vector %0d", v), w, VEC[v][15:0]);
      end else begin
        frame(VEC[v][44:42], VEC[v][41], VEC[v][40:32], VEC[v][31:16]);
        tick(PROG + 20);
      end
    end

    // R2 leading zeros
    frame(WR, 1, 9'd12, 16'hBEEF); tick(PROG + 20);
    rd(1, 9'd12, w, 7);
    chk("R2 leading zeros", w, 16'hBEEF);

    // R4 clock stall
    rd(1, 9'd12, w, 0, 80);
    chk("R4 clock stall", w, 16'hBEEF);

    // R1 aborted frame
    org16 = 1; sel_on; bit_out(1); send(2'b01, 2); send(9, 8); send(8'h55, 8); sel_off;
    tick(PROG + 20);
    rd(1, 9'd9, w);
    chk("R1 aborted frame", w, 16'hFFFF);

    // R9 busy then ready, R10 clear
    frame(WR, 1, 9'd9, 16'h1111); tick(20); sel_on;
    chk("R9 busy shown", {14'd0, sdo_oe, sdo}, 16'h0002);
    tick(PROG);
    chk("R9 ready shown", {14'd0, sdo_oe, sdo}, 16'h0003);
    bit_out(1); sel_off; sel_on;
    chk("R10 status cleared", {15'd0, sdo_oe}, 16'h0000);
    sel_off;

    // R9 select held low for whole cycle
    frame(WR, 1, 9'd6, 16'h6666); tick(PROG + 20); sel_on;
    chk("R9 high impedance", {15'd0, sdo_oe}, 16'h0000);
    sel_off;

    // R8 frame ignored while busy, and duration
    frame(WR, 1, 9'd3, 16'h3333); sel_on;
    frame(EWDS, 1, 9'd0, 16'h0); sel_on;
    chk("R8 still busy", {14'd0, sdo_oe, sdo}, 16'h0002);
    tick(60);
    chk("R8 cycle ended", {14'd0, sdo_oe, sdo}, 16'h0003);
    sel_off;
    frame(WR, 1, 9'd4, 16'h4444); tick(PROG + 20);
    rd(1, 9'd4, w);
    chk("R8 command while busy ignored", w, 16'h4444);
    rd(1, 9'd3, w);
    chk("R8 completed with select low", w, 16'h3333);

    // R12 trailing frame after a completed one
    frame(EWEN, 1, 9'd0, 16'h0, 0);
    bit_out(1); send(2'b01, 2); send(8, 8); send(16'h8888, 16); sel_off;
    tick(PROG + 20);
    rd(1, 9'd8, w);
    chk("R12 trailing bits ignored", w, 16'hFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule